// File: doc/BRIEF.md
# Toggle-indexed compressed table reader

This block returns one W-bit word of a lookup table when it is given the word's index. Each bit column of the table is kept in one of two ways. A compressed column keeps only an ascending list of the entry indices at which the column's bit differs from the entry above it. A direct column keeps every bit in a plain word memory. A per-column flag selects which form each column uses.

For a compressed column, the bit is the parity of how many listed indices are less than or equal to the requested index. Every column is taken to hold 0 above entry 0. Each list is scanned one element per cycle, and all columns scan at the same time. A per-column length register bounds each scan. The scan also stops at the first listed index that is above the request. The word is presented once every column has finished.

The table contents are written through simple load ports before queries are issued. These ports take list elements, list lengths, the column modes and the direct-memory words.

Top module: `toggle_table_reader`

## Requirements
- R1: After reset, out_valid is 0, entry is 0 and idx_ready is 1. Every column is in direct mode with an empty toggle list.
- R2: A request is taken on a clock edge where idx_valid and idx_ready are both 1, and idx_ready is 0 in the following cycle. A request offered while idx_ready is 0 is ignored and produces no result.
- R3: For a column whose mode bit is 1, bit c of the result is 1 exactly when an odd number of that column's stored list elements are less than or equal to the requested index.
- R4: A list element equal to the requested index counts toward that parity, so the bit at an index where the column toggles already shows the new value.
- R5: A compressed column whose length register is 0 gives 0 for every index.
- R6: For a column whose mode bit is 0, bit c of the result is bit c of the direct-memory word stored at the requested index.
- R7: Bit c of the mode word loaded through ld_mode_val selects the form of column c: 1 means compressed and 0 means direct. A reload takes effect on the next request.
- R8: out_valid is high for exactly one cycle per accepted request, and idx_ready is 1 in that cycle. entry changes only in a cycle where out_valid is 1.
- R9: out_valid rises no more than TMAX+3 clock edges after the edge that accepted the request.
- R10: ld_tog writes ld_idx into slot ld_slot of column ld_col's list, and ld_len sets that column's list length to ld_len_val. ld_dir writes word ld_dir_data at ld_dir_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_valid | input | 1 | Request strobe |
| idx | input | IW | Requested entry index |
| idx_ready | output | 1 | High when a new request can be taken |
| out_valid | output | 1 | One-cycle result strobe |
| entry | output | W | Reconstructed table word |
| ld_tog | input | 1 | Write one toggle-list element |
| ld_len | input | 1 | Write one column's list length |
| ld_col | input | CW | Column addressed by ld_tog and ld_len |
| ld_slot | input | SW | List position written by ld_tog |
| ld_idx | input | IW | Toggle index value written by ld_tog |
| ld_len_val | input | LW | List length written by ld_len |
| ld_mode | input | 1 | Write the mode word |
| ld_mode_val | input | W | Per-column mode, 1 = compressed |
| ld_dir | input | 1 | Write one direct-memory word |
| ld_dir_addr | input | IW | Direct-memory address |
| ld_dir_data | input | W | Direct-memory data |

## Verification
The checker watches the handshake on every cycle. It confirms that idx_ready drops after an accept, that the result strobe lasts a single cycle while idx_ready is high, that entry moves only under the strobe, and that no request stays busy beyond the latency bound. It also confirms that any compressed column with an empty list reads 0 whenever a result appears.

Whether each bit has the right value needs the bench's scenarios. These compare the reconstructed words with a table computed in the bench, at every index and including the toggle points. They also change the mode word so that the bits come from the other storage, and they check that requests sent while the block is busy are dropped.

// File: rtl/toggle_table_reader.sv
module toggle_table_reader #(
  parameter int W    = 8,
  parameter int NENT = 16,
  parameter int TMAX = 16,
  localparam int IW  = $clog2(NENT),
  localparam int CW  = $clog2(W),
  localparam int SW  = $clog2(TMAX),
  localparam int LW  = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_valid,
  input  logic [IW-1:0] idx,
  output logic          idx_ready,
  output logic          out_valid,
  output logic [W-1:0]  entry,
  input  logic          ld_tog,
  input  logic          ld_len,
  input  logic [CW-1:0] ld_col,
  input  logic [SW-1:0] ld_slot,
  input  logic [IW-1:0] ld_idx,
  input  logic [LW-1:0] ld_len_val,
  input  logic          ld_mode,
  input  logic [W-1:0]  ld_mode_val,
  input  logic          ld_dir,
  input  logic [IW-1:0] ld_dir_addr,
  input  logic [W-1:0]  ld_dir_data
);

  logic [IW-1:0]         tog_mem [W][TMAX];
  logic [W-1:0]          dir_mem [NENT];
  logic [W-1:0]          col_mode;
  logic [W-1:0][LW-1:0]  col_len;

  logic                  busy;
  logic [IW-1:0]         idx_q;
  logic [W-1:0][LW-1:0]  ptr;
  logic [W-1:0]          par;
  logic [W-1:0]          done;
  logic [W-1:0]          dir_rd;
  logic [W-1:0]          result;

  assign idx_ready = !busy;
  assign dir_rd    = dir_mem[idx_q];
  assign result    = (col_mode & par) | (~col_mode & dir_rd);

  always_ff @(posedge clk) begin
    if (ld_tog) tog_mem[ld_col][ld_slot] <= ld_idx;
    if (ld_dir) dir_mem[ld_dir_addr] <= ld_dir_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_mode <= '0;
      col_len  <= '0;
    end else begin
      if (ld_mode) col_mode <= ld_mode_val;
      if (ld_len)  col_len[ld_col] <= ld_len_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      entry     <= '0;
      idx_q     <= '0;
      ptr       <= '0;
      par       <= '0;
      done      <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (idx_valid) begin
          busy  <= 1'b1;
          idx_q <= idx;
          for (int c = 0; c < W; c++) begin
            ptr[c]  <= '0;
            par[c]  <= 1'b0;
            done[c] <= !col_mode[c] || (col_len[c] == '0);
          end
        end
      end else if (&done) begin
        busy      <= 1'b0;
        out_valid <= 1'b1;
        entry     <= result;
      end else begin
        for (int c = 0; c < W; c++) begin
          if (!done[c]) begin
            if (ptr[c] < col_len[c] && tog_mem[c][ptr[c][SW-1:0]] <= idx_q) begin
              par[c] <= ~par[c];
              ptr[c] <= ptr[c] + LW'(1);
            end else begin
              done[c] <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/ttr_checker.sv
module ttr_checker #(
  parameter int W    = 8,
  parameter int TMAX = 16,
  localparam int LW  = $clog2(TMAX + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 idx_valid,
  input logic                 idx_ready,
  input logic                 out_valid,
  input logic [W-1:0]         entry,
  input logic [W-1:0]         col_mode,
  input logic [W-1:0][LW-1:0] col_len
);

  logic [LW+1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (idx_ready) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 1'b1;
  end

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && idx_ready |=> !idx_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r8_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> idx_ready);

  a_r8_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(entry) |-> out_valid);

  a_r9_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= (LW+2)'(TMAX + 3));

  for (genvar c = 0; c < W; c++) begin : g_empty
    a_r5_empty_list_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && col_mode[c] && (col_len[c] == '0) |-> !entry[c]);
  end

endmodule

bind toggle_table_reader ttr_checker #(.W(W), .TMAX(TMAX)) u_ttr_checker (
  .clk(clk), .rst_n(rst_n), .idx_valid(idx_valid), .idx_ready(idx_ready),
  .out_valid(out_valid), .entry(entry), .col_mode(col_mode), .col_len(col_len)
);

// File: tb/tb_toggle_table_reader.sv
module tb_toggle_table_reader;
  localparam int W = 8, NENT = 16, TMAX = 16;
  localparam int IW = 4, CW = 3, SW = 4, LW = 5;
  localparam logic [W-1:0] MODE_A = 8'b1101_0110;
  localparam logic [IW-1:0] QV [16] = '{4'd0, 4'd15, 4'd7, 4'd1, 4'd8, 4'd3, 4'd12, 4'd5,
                                        4'd10, 4'd2, 4'd14, 4'd6, 4'd9, 4'd4, 4'd13, 4'd11};

  logic clk = 0, rst_n = 0;
  logic idx_valid = 0; logic [IW-1:0] idx = 0;
  logic idx_ready, out_valid; logic [W-1:0] entry;
  logic ld_tog = 0, ld_len = 0, ld_mode = 0, ld_dir = 0;
  logic [CW-1:0] ld_col = 0; logic [SW-1:0] ld_slot = 0; logic [IW-1:0] ld_idx = 0;
  logic [LW-1:0] ld_len_val = 0; logic [W-1:0] ld_mode_val = 0;
  logic [IW-1:0] ld_dir_addr = 0; logic [W-1:0] ld_dir_data = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  toggle_table_reader #(.W(W), .NENT(NENT), .TMAX(TMAX)) dut (.*);

  function automatic logic [W-1:0] ref_val(input int i);
    return W'((i * 29 + 7) ^ (i << 3));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic load_lists();
    for (int c = 0; c < W; c++) begin
      int cnt = 0; logic prev = 0;
      for (int i = 0; i < NENT; i++) begin
        logic b = ref_val(i)[c];
        if (b != prev) begin
          @(negedge clk); ld_tog = 1; ld_col = CW'(c); ld_slot = SW'(cnt); ld_idx = IW'(i);
          @(negedge clk); ld_tog = 0; cnt++;
        end
        prev = b;
      end
      set_len(c, cnt);
    end
  endtask

  task automatic set_len(input int c, input int n);
    @(negedge clk); ld_len = 1; ld_col = CW'(c); ld_len_val = LW'(n);
    @(negedge clk); ld_len = 0;
  endtask

  task automatic set_mode(input logic [W-1:0] m);
    @(negedge clk); ld_mode = 1; ld_mode_val = m;
    @(negedge clk); ld_mode = 0;
  endtask

  task automatic query(input int i, input logic [W-1:0] exp, input string tag);
    int n = 0;
    @(negedge clk); idx = IW'(i); idx_valid = 1;
    @(negedge clk); idx_valid = 0;
    chk(idx_ready == 0, "R2 ready low after accept", idx_ready, 0);
    while (!out_valid && n < 40) begin @(negedge clk); n++; end
    chk(n <= TMAX + 2, "R9 latency", n + 1, TMAX + 3);
    chk(entry === exp, tag, entry, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && entry == 0 && idx_ready == 1, "R1 reset outputs",
        {out_valid, entry, idx_ready}, 1);
    rst_n = 1;
    for (int i = 0; i < NENT; i++) begin
      @(negedge clk); ld_dir = 1; ld_dir_addr = IW'(i); ld_dir_data = ref_val(i) ^ MODE_A;
      @(negedge clk); ld_dir = 0;
    end
    // R1: modes default to direct, so the direct word is returned
    query(5, ref_val(5) ^ MODE_A, "R1 default direct mode");
    load_lists();
    set_mode(MODE_A);
    // R3 R4 R6 R10: full sweep, every toggle point is a queried index
    foreach (QV[k]) query(QV[k], ref_val(QV[k]), "R3 R4 R6 R10 sweep");

    // R7: switch every column to direct
    set_mode('0);
    query(9, ref_val(9) ^ MODE_A, "R7 all direct");
    set_mode('1);
    query(9, ref_val(9), "R7 all compressed");
    query(0, ref_val(0), "R4 toggle at index 0");
    set_mode(MODE_A);

    // R5: empty list on compressed column 2
    set_len(2, 0);
    query(7, ref_val(7) & ~8'h04, "R5 empty list column");
    query(15, ref_val(15) & ~8'h04, "R5 empty list last index");
    load_lists();

    // R2: request during busy ignored
    begin
      int n = 0; int extra = 0;
      @(negedge clk); idx = 4'd3; idx_valid = 1;
      @(negedge clk); idx = 4'd12;
      @(negedge clk); idx_valid = 0;
      while (!out_valid && n < 40) begin @(negedge clk); n++; end
      chk(entry === ref_val(3), "R2 busy request ignored", entry, ref_val(3));
      @(negedge clk);
      chk(out_valid == 0, "R8 single pulse", out_valid, 0);
      repeat (30) begin @(negedge clk); if (out_valid) extra++; end
      chk(extra == 0, "R2 no result for dropped request", extra, 0);
      chk(entry === ref_val(3), "R8 entry held", entry, ref_val(3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule